// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block collects the five interrupt causes of a 16550-style UART: receiver line error, receive data ready, character timeout, transmit holding register empty and modem status change. It masks them with a four-bit enable register and reports the most urgent enabled cause. The report comes out as an identification byte and also as a single active-high interrupt line. The surrounding UART supplies event pulses and a data-ready level. It also supplies the host access strobes, and each strobe removes its own cause.

Line errors, timeout, transmit-empty and modem changes are held in pending bits inside the block. Data ready is a level that the receive buffer logic drives, so it drops by itself when the buffer is read or the fill falls below the trigger. When a host reads the identification byte, the transmit-empty cause is acknowledged only if that same read returned the transmit-empty code. A less urgent cause is therefore never dropped while a more urgent one hides it.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 01h, the interrupt line is low and the enable register holds zero.
- R2: An enable write stores `ier_wdata[3:0]`: bit 0 enables data ready and timeout, bit 1 enables transmit-empty, bit 2 enables line error and bit 3 enables modem status; bits 7:4 have no effect.
- R3: Among enabled pending causes the reported one is chosen in this order: line error, data ready, timeout, transmit-empty, modem status.
- R4: Identification bits 3:0 read 6h for line error, 4h for data ready, Ch for timeout, 2h for transmit-empty, 0h for modem status and 1h when nothing is pending (bit 0 is an active-low pending flag).
- R5: Identification bit 7 equals `fifo_en`, bits 6:4 read zero, and bit 3 is set only for the timeout code in FIFO mode.
- R6: A pulse on any bit of `err_evt` (overrun, parity, framing, break) makes the line error cause pending; `lsr_rd` clears it.
- R7: The data ready cause follows the `rx_ready` level with no storage.
- R8: `tmo_evt` makes the timeout cause pending only while `fifo_en` is high; `rbr_rd` clears it, and so does `fifo_en` low.
- R9: `thre_evt` makes the transmit-empty cause pending; `thr_wr` clears it, and `iir_rd` clears it only when the byte read in that cycle carries code 2h.
- R10: `msr_evt` makes the modem status cause pending; `msr_rd` clears it.
- R11: `int_o` is high exactly when an enabled cause is pending; with enable bits 3:0 all zero it stays low.
- R12: A set event that arrives in the same cycle as its clear strobe leaves the cause pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode is on |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Enable register write data |
| err_evt | input | 4 | Receiver error pulses: overrun, parity, framing, break |
| rx_ready | input | 1 | Receive data ready or trigger level reached (level) |
| tmo_evt | input | 1 | Character timeout pulse |
| thre_evt | input | 1 | Transmit holding register became empty (pulse) |
| msr_evt | input | 1 | Modem status input changed (pulse) |
| rbr_rd | input | 1 | Host read of the receive buffer |
| thr_wr | input | 1 | Host write of the transmit holding register |
| iir_rd | input | 1 | Host read of the identification byte |
| lsr_rd | input | 1 | Host read of the line status register |
| msr_rd | input | 1 | Host read of the modem status register |
| iir_o | output | 8 | Identification byte |
| int_o | output | 1 | Interrupt request, active high |

## Verification
The properties assume that every event and strobe input lasts one cycle and that `rx_ready` is already a clean level coming from the receive buffer logic. They do not model how a real host orders its reads. The bench drives all inputs on the falling edge, holds each pulse for exactly one cycle and returns it to zero. Before each combination it resets the block, so no earlier pending state carries into the next case. It then sweeps every mix of the five causes against all sixteen enable patterns in both FIFO modes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IER_W  = 4;
    localparam int BYTE_W = 8;
    localparam int ERR_W  = 4;
    localparam int LAT_N  = 4;   // causes held in pending bits

    // indexes of the held causes
    localparam int P_LINE  = 0;
    localparam int P_TMO   = 1;
    localparam int P_THRE  = 2;
    localparam int P_MODEM = 3;

    typedef enum logic [3:0] {
        IID_MODEM  = 4'h0,
        IID_NONE   = 4'h1,
        IID_THRE   = 4'h2,
        IID_RXDATA = 4'h4,
        IID_LINE   = 4'h6,
        IID_TMO    = 4'hC
    } iid_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic tmo;
        logic thre;
        logic modem;
    } cause_t;

    // fixed urgency order; the first active cause wins
    function automatic iid_e pick_iid(cause_t c);
        iid_e r;
        if (c.line)        r = IID_LINE;
        else if (c.rxdata) r = IID_RXDATA;
        else if (c.tmo)    r = IID_TMO;
        else if (c.thre)   r = IID_THRE;
        else if (c.modem)  r = IID_MODEM;
        else               r = IID_NONE;
        return r;
    endfunction

endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [IER_W-1:0]  en_q
);
    logic unused_hi;
    assign unused_hi = ^wdata[BYTE_W-1:IER_W];

    always_ff @(posedge clk) begin
        if (rst)     en_q <= '0;
        else if (wr) en_q <= wdata[IER_W-1:0];
    end
endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           pend_q[i] <= 1'b0;
            else if (set_i[i]) pend_q[i] <= 1'b1;   // set beats clear
            else if (clr_i[i]) pend_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [LAT_N-1:0]  pend,
    input  logic              rx_ready,
    input  logic [IER_W-1:0]  en,
    input  logic              fifo_en,
    output iid_e              iid,
    output logic [BYTE_W-1:0] iir,
    output logic              irq
);
    cause_t live;

    always_comb begin
        live.line   = pend[P_LINE]  & en[2];
        live.rxdata = rx_ready      & en[0];
        live.tmo    = pend[P_TMO]   & en[0] & fifo_en;
        live.thre   = pend[P_THRE]  & en[1];
        live.modem  = pend[P_MODEM] & en[3];
        iid = pick_iid(live);
        iir = {fifo_en, 3'b000, iid};
        irq = (iid != IID_NONE);
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_en,
    input  logic        ier_wr,
    input  logic [7:0]  ier_wdata,
    input  logic [3:0]  err_evt,
    input  logic        rx_ready,
    input  logic        tmo_evt,
    input  logic        thre_evt,
    input  logic        msr_evt,
    input  logic        rbr_rd,
    input  logic        thr_wr,
    input  logic        iir_rd,
    input  logic        lsr_rd,
    input  logic        msr_rd,
    output logic [7:0]  iir_o,
    output logic        int_o
);
    logic [IER_W-1:0] ier_q;
    logic [LAT_N-1:0] pend_set, pend_clr, pend_q;
    iid_e             cur_iid;

    irq_en_reg u_en (
        .clk(clk), .rst(rst), .wr(ier_wr), .wdata(ier_wdata), .en_q(ier_q)
    );

    always_comb begin
        pend_set[P_LINE]  = |err_evt;
        pend_clr[P_LINE]  = lsr_rd;
        pend_set[P_TMO]   = tmo_evt & fifo_en;
        pend_clr[P_TMO]   = rbr_rd | ~fifo_en;
        pend_set[P_THRE]  = thre_evt;
        pend_clr[P_THRE]  = thr_wr | (iir_rd & (cur_iid == IID_THRE));
        pend_set[P_MODEM] = msr_evt;
        pend_clr[P_MODEM] = msr_rd;
    end

    irq_pend_bits #(.N(LAT_N)) u_pend (
        .clk(clk), .rst(rst), .set_i(pend_set), .clr_i(pend_clr), .pend_q(pend_q)
    );

    irq_prio_enc u_enc (
        .pend(pend_q), .rx_ready(rx_ready), .en(ier_q), .fifo_en(fifo_en),
        .iid(cur_iid), .iir(iir_o), .irq(int_o)
    );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_en,
    input logic [3:0] ier_en,
    input logic [3:0] err_evt,
    input logic       rx_ready,
    input logic       thre_evt,
    input logic       msr_evt,
    input logic       thr_wr,
    input logic       lsr_rd,
    input logic       msr_rd,
    input logic [7:0] iir_o,
    input logic       int_o
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (iir_o[3:0] == 4'h1 && !int_o)); // R1
    AST_RXDATA_RANK: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && ier_en[0] && iir_o[3:0] != 4'h6) |-> iir_o[3:0] == 4'h4); // R3
    AST_UPPER_BITS: assert property (@(posedge clk) disable iff (rst)
        (iir_o[6:4] == 3'b000 && iir_o[7] == fifo_en)); // R5
    AST_TMO_BIT: assert property (@(posedge clk) disable iff (rst)
        iir_o[3] |-> (iir_o[2] && fifo_en)); // R5
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && err_evt == 4'h0) |=> iir_o[3:0] != 4'h6); // R6
    AST_THRE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !thre_evt) |=> iir_o[3:0] != 4'h2); // R9
    AST_MODEM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (msr_rd && !msr_evt) |=> iir_o[3:0] != 4'h0); // R10
    AST_INT_MATCH: assert property (@(posedge clk) disable iff (rst)
        int_o == !iir_o[0]); // R11
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
        (ier_en == 4'h0) |-> !int_o); // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier_en(ier_q), .err_evt(err_evt),
    .rx_ready(rx_ready), .thre_evt(thre_evt), .msr_evt(msr_evt), .thr_wr(thr_wr),
    .lsr_rd(lsr_rd), .msr_rd(msr_rd), .iir_o(iir_o), .int_o(int_o)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0, ier_wr = 1'b0, rx_ready = 1'b0;
    logic [7:0] ier_wdata = 8'h00;
    logic [3:0] err_evt = 4'h0;
    logic       tmo_evt = 1'b0, thre_evt = 1'b0, msr_evt = 1'b0;
    logic       rbr_rd = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0, lsr_rd = 1'b0, msr_rd = 1'b0;
    logic [7:0] iir_o;
    logic       int_o;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .err_evt(err_evt), .rx_ready(rx_ready), .tmo_evt(tmo_evt), .thre_evt(thre_evt),
        .msr_evt(msr_evt), .rbr_rd(rbr_rd), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .lsr_rd(lsr_rd), .msr_rd(msr_rd), .iir_o(iir_o), .int_o(int_o)
    );

    function automatic logic [7:0] model(bit ls, bit rd, bit to, bit th, bit ms,
                                         logic [3:0] en, bit fe);
        logic [3:0] c;
        if (ls && en[2])            c = 4'h6;
        else if (rd && en[0])       c = 4'h4;
        else if (to && en[0] && fe) c = 4'hC;
        else if (th && en[1])       c = 4'h2;
        else if (ms && en[3])       c = 4'h0;
        else                        c = 4'h1;
        return {fe, 3'b000, c};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk_iir(string tag, logic [7:0] exp);
        chk(tag, iir_o, exp);
        chk({tag, " int"}, {7'd0, int_o}, {7'd0, ~exp[0]});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic write_ier(logic [7:0] v);
        @(negedge clk); ier_wr = 1'b1; ier_wdata = v;
        @(negedge clk); ier_wr = 1'b0; ier_wdata = 8'h00;
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk_iir("R1 reset", 8'h01);
        rx_ready = 1'b1;
        @(negedge clk);
        chk_iir("R1 enable zero after reset", 8'h01);
        rx_ready = 1'b0;

        // R2 R3 R4 R5 R7 R8 R11: sweep causes x enables x mode
        for (int fe = 0; fe < 2; fe++) begin
            for (int en = 0; en < 16; en++) begin
                for (int s = 0; s < 32; s++) begin
                    do_reset();
                    fifo_en = fe[0];
                    write_ier({en[3:0] ^ 4'h0, en[3:0]});
                    err_evt  = s[0] ? 4'h1 : 4'h0;
                    tmo_evt  = s[2];
                    thre_evt = s[3];
                    msr_evt  = s[4];
                    rx_ready = s[1];
                    @(negedge clk);
                    err_evt = 4'h0; tmo_evt = 1'b0; thre_evt = 1'b0; msr_evt = 1'b0;
                    chk_iir("R3 R4 sweep",
                            model(s[0], s[1], s[2], s[3], s[4], en[3:0], fe[0]));
                    rx_ready = 1'b0;
                end
            end
        end

        // R2 upper bits ignored
        do_reset(); fifo_en = 1'b1;
        write_ier(8'hF0);
        err_evt = 4'h1; thre_evt = 1'b1; msr_evt = 1'b1; tmo_evt = 1'b1; rx_ready = 1'b1;
        @(negedge clk);
        err_evt = 4'h0; thre_evt = 1'b0; msr_evt = 1'b0; tmo_evt = 1'b0;
        chk_iir("R2 upper enable bits", 8'h81);
        rx_ready = 1'b0;
        write_ier(8'h0F);
        chk_iir("R2 held causes appear once enabled", 8'h86);

        // R6 each error bit sets line cause, read clears
        for (int b = 0; b < 4; b++) begin
            do_reset(); fifo_en = 1'b0;
            write_ier(8'h04);
            err_evt = 4'h1 << b;
            @(negedge clk); err_evt = 4'h0;
            chk_iir("R6 error bit sets", 8'h06);
            lsr_rd = 1'b1;
            @(negedge clk); lsr_rd = 1'b0;
            chk_iir("R6 lsr read clears", 8'h01);
        end

        // R12 set and clear together
        err_evt = 4'h2; lsr_rd = 1'b1;
        @(negedge clk); err_evt = 4'h0; lsr_rd = 1'b0;
        chk_iir("R12 set wins over clear", 8'h06);

        // R8 timeout ignored outside FIFO mode, cleared by buffer read
        do_reset(); fifo_en = 1'b0;
        write_ier(8'h01);
        tmo_evt = 1'b1;
        @(negedge clk); tmo_evt = 1'b0;
        fifo_en = 1'b1;
        @(negedge clk);
        chk_iir("R8 timeout ignored in char mode", 8'h81);
        tmo_evt = 1'b1;
        @(negedge clk); tmo_evt = 1'b0;
        chk_iir("R8 timeout code", 8'h8C);
        rbr_rd = 1'b1;
        @(negedge clk); rbr_rd = 1'b0;
        chk_iir("R8 buffer read clears timeout", 8'h81);
        tmo_evt = 1'b1;
        @(negedge clk); tmo_evt = 1'b0; fifo_en = 1'b0;
        @(negedge clk); fifo_en = 1'b1;
        @(negedge clk);
        chk_iir("R8 leaving FIFO mode clears timeout", 8'h81);

        // R7 data ready follows level
        rx_ready = 1'b1;
        @(negedge clk);
        chk_iir("R7 data ready level", 8'h84);
        rx_ready = 1'b0;
        @(negedge clk);
        chk_iir("R7 level drop", 8'h81);

        // R9 identification read acknowledges transmit-empty only when shown
        do_reset(); fifo_en = 1'b0;
        write_ier(8'h0F);
        thre_evt = 1'b1; msr_evt = 1'b1;
        @(negedge clk); thre_evt = 1'b0; msr_evt = 1'b0;
        chk_iir("R9 thre shown", 8'h02);
        iir_rd = 1'b1;
        @(negedge clk); iir_rd = 1'b0;
        chk_iir("R9 read ack reveals modem", 8'h00);
        msr_rd = 1'b1;
        @(negedge clk); msr_rd = 1'b0;
        chk_iir("R10 msr read clears", 8'h01);
        thre_evt = 1'b1; err_evt = 4'h8;
        @(negedge clk); thre_evt = 1'b0; err_evt = 4'h0;
        chk_iir("R9 line error hides thre", 8'h06);
        iir_rd = 1'b1;
        @(negedge clk); iir_rd = 1'b0;
        lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
        chk_iir("R9 thre kept after hidden read", 8'h02);
        thr_wr = 1'b1;
        @(negedge clk); thr_wr = 1'b0;
        chk_iir("R9 holding write clears", 8'h01);

        // R11 masking all enables drops the line
        msr_evt = 1'b1;
        @(negedge clk); msr_evt = 1'b0;
        chk_iir("R11 modem raises int", 8'h00);
        write_ier(8'h00);
        chk_iir("R11 zero enable forces low", 8'h01);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule